// File: doc/BRIEF.md
# Dual-Buffer Frame Transmit Controller

This block is the send half of a small memory-mapped Ethernet MAC. The host sees two 2 KB windows, one for each frame buffer. It writes frame words into a window, stores a byte count in the length word near the top of that window, and then writes the command word at the very top of the window. Depending on the command bits, the block either streams the counted bytes out as a byte stream, or copies the first six bytes of the buffer into the station address register. The receive side of the MAC uses that register for its filter.

Each buffer has its own command word. A single global interrupt enable, stored in the first window only, gates the completion pulse for both buffers. Frame words are big-endian: the byte at the lowest address sits in bits 31:24 of its word and leaves the block first. Only one command runs at a time. A command posted on the other buffer waits until the current one has finished.

The outgoing stream uses valid/ready. A beat is taken on a clock edge where both `tx_valid` and `tx_ready` are high. While `tx_valid` is high and `tx_ready` is low, the block keeps `tx_valid`, `tx_data` and `tx_last` unchanged. `tx_valid` never drops before the beat is taken. `tx_ready` may be held low for any length of time.

Top module: `ethtx_ctrl`

## Requirements
- R1: After reset, both command words read 0, `irq` is low, `tx_valid` is low and `station_addr` equals the parameter `STATION_RST`.
- R2: Word offsets within window b (b = address bit 11): 0x7F4 is the length, which keeps only its low 11 bits. 0x7F8 in window 0 is the global enable, which keeps only bit 31. 0x7FC is the command word. In the command word, bit 0 is start, bit 1 is address-load and bit 3 is interrupt enable. Every other bit reads 0, and address-load is stored only when start is also written as 1.
- R3: A command write with start=1 and address-load=0 sends exactly the number of bytes held in the length register. Bytes go out in ascending address order, each word sending bits 31:24 first, and `tx_last` is high on the final byte only.
- R4: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold their values.
- R5: A transmit command with length 0 completes without sending any byte.
- R6: A command write with start=1 and address-load=1 sends no bytes and sets `station_addr` to the buffer's first six bytes. The byte at the lowest address goes into bits 47:40.
- R7: Start and address-load read back as 1 while the command runs and read 0 after it finishes. A command write to a buffer whose start bit reads 1 changes nothing, and this includes a write that falls in the completion cycle.
- R8: When a command finishes, `irq` is high for exactly one cycle, but only if that buffer's interrupt-enable bit and global-enable bit 31 are both 1. Otherwise `irq` stays low.
- R9: A command posted on one buffer while the other buffer's command is running is carried out after that command has finished. It is never lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 12 | Host write byte address |
| wr_data | input | 32 | Host write data |
| rd_addr | input | 12 | Host read byte address |
| rd_data | output | 32 | Host read data (combinational) |
| tx_valid | output | 1 | Stream byte valid |
| tx_ready | input | 1 | Stream sink ready |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of frame |
| irq | output | 1 | One-cycle completion pulse |
| station_addr | output | 48 | Station address for the receive filter |

## Verification
Command completion and a host write to the same command word can fall in the same cycle. When they do, completion wins and the write is dropped. The bench provokes this by watching for the final transmit beat and issuing a start write in the very next cycle, which is the completion cycle. It then checks that the command word reads idle and that no second frame is sent. A start on the second buffer posted while the first is still sending, with `tx_ready` held low, is also checked: both frames must arrive in order and complete.

// File: rtl/ethtx_pkg.sv
`timescale 1ns/1ps
package ethtx_pkg;
  localparam int NBUF    = 2;
  localparam int CMD_S   = 0;
  localparam int CMD_P   = 1;
  localparam int CMD_I   = 3;
  localparam int GEN_BIT = 31;

  typedef struct packed {
    logic irq_en;
    logic prog;
    logic start;
  } cmd_t;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_RUN  = 2'd1,
    ENG_FIN  = 2'd2
  } eng_state_t;
endpackage

// File: rtl/ethtx_bufmem.sv
`timescale 1ns/1ps
module ethtx_bufmem #(
  parameter int WORDS = 512,
  localparam int WA = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic          we_buf,
  input  logic [WA-1:0] we_word,
  input  logic [31:0]   we_data,
  input  logic          h_buf,
  input  logic [WA-1:0] h_word,
  output logic [31:0]   h_q,
  input  logic          e_buf,
  input  logic [WA-1:0] e_word,
  output logic [31:0]   e_q,
  output logic [31:0]   head0,
  output logic [31:0]   head1
);
  logic [1:0][31:0] h_arr, e_arr, h0_arr, h1_arr;

  for (genvar b = 0; b < 2; b++) begin : g_buf
    logic [31:0] mem [WORDS];
    always_ff @(posedge clk) begin
      if (we && (we_buf == b[0])) mem[we_word] <= we_data;
    end
    assign h_arr[b]  = mem[h_word];
    assign e_arr[b]  = mem[e_word];
    assign h0_arr[b] = mem[0];
    assign h1_arr[b] = mem[1];
  end

  assign h_q   = h_arr[h_buf];
  assign e_q   = e_arr[e_buf];
  assign head0 = h0_arr[e_buf];
  assign head1 = h1_arr[e_buf];
endmodule

// File: rtl/ethtx_engine.sv
`timescale 1ns/1ps
module ethtx_engine
  import ethtx_pkg::*;
#(
  parameter int LEN_W = 11,
  localparam int WA = LEN_W - 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            pend,
  input  logic [1:0]            prog,
  input  logic [1:0][LEN_W-1:0] len,
  input  logic [31:0]           word_q,
  output logic                  sel,
  output logic [WA-1:0]         rd_word,
  output logic                  tx_valid,
  input  logic                  tx_ready,
  output logic [7:0]            tx_data,
  output logic                  tx_last,
  output logic                  done
);
  eng_state_t       state;
  logic [LEN_W-1:0] len_q, idx;
  logic             pick, at_end;

  assign pick   = pend[0] ? 1'b0 : 1'b1;
  assign at_end = (idx == len_q - LEN_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ENG_IDLE;
      sel   <= 1'b0;
      len_q <= '0;
      idx   <= '0;
    end else begin
      case (state)
        ENG_IDLE: if (|pend) begin
          sel   <= pick;
          len_q <= len[pick];
          idx   <= '0;
          state <= (prog[pick] || len[pick] == '0) ? ENG_FIN : ENG_RUN;
        end
        ENG_RUN: if (tx_ready) begin
          if (at_end) state <= ENG_FIN;
          else        idx   <= idx + LEN_W'(1);
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end

  assign rd_word  = idx[LEN_W-1:2];
  assign tx_valid = (state == ENG_RUN);
  assign tx_last  = tx_valid && at_end;
  assign done     = (state == ENG_FIN);

  always_comb begin
    case (idx[1:0])
      2'd0:    tx_data = word_q[31:24];
      2'd1:    tx_data = word_q[23:16];
      2'd2:    tx_data = word_q[15:8];
      default: tx_data = word_q[7:0];
    endcase
  end

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last)); // R4
  AST_LAST_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready && tx_last |=> done && !tx_valid); // R3
endmodule

// File: rtl/ethtx_regs.sv
`timescale 1ns/1ps
module ethtx_regs
  import ethtx_pkg::*;
#(
  parameter int          LEN_W       = 11,
  parameter logic [47:0] STATION_RST = 48'h0200_0000_0001
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            cmd_we,
  input  logic [1:0]            len_we,
  input  logic                  gen_we,
  input  logic [31:0]           wdata,
  input  logic                  done,
  input  logic                  done_sel,
  input  logic [31:0]           head0,
  input  logic [31:0]           head1,
  output cmd_t [1:0]            cmd,
  output logic [1:0][LEN_W-1:0] len,
  output logic                  gen,
  output logic                  irq,
  output logic [47:0]           station
);
  logic unused_bits;
  assign unused_bits = ^{head1[15:0]};

  for (genvar b = 0; b < NBUF; b++) begin : g_reg
    logic fin_here;
    assign fin_here = done && (done_sel == b[0]);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cmd[b] <= '0;
        len[b] <= '0;
      end else begin
        if (fin_here) begin
          cmd[b].start <= 1'b0;
          cmd[b].prog  <= 1'b0;
        end else if (cmd_we[b] && !cmd[b].start) begin
          cmd[b].start  <= wdata[CMD_S];
          cmd[b].prog   <= wdata[CMD_P] & wdata[CMD_S];
          cmd[b].irq_en <= wdata[CMD_I];
        end
        if (len_we[b]) len[b] <= wdata[LEN_W-1:0];
      end
    end

    AST_BUSY_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      cmd[b].start && !fin_here |=> $stable(cmd[b])); // R7
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gen     <= 1'b0;
      irq     <= 1'b0;
      station <= STATION_RST;
    end else begin
      if (gen_we) gen <= wdata[GEN_BIT];
      irq <= done && cmd[done_sel].irq_en && gen;
      if (done && cmd[done_sel].prog) station <= {head0, head1[31:16]};
    end
  end

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R8
  AST_IRQ_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(done)); // R8
  AST_STATION_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(station) |-> $past(done)); // R6
endmodule

// File: rtl/ethtx_ctrl.sv
`timescale 1ns/1ps
module ethtx_ctrl
  import ethtx_pkg::*;
#(
  parameter int          BUF_BYTES   = 2048,
  parameter logic [47:0] STATION_RST = 48'h0200_0000_0001,
  localparam int WORDS  = BUF_BYTES / 4,
  localparam int WA     = $clog2(WORDS),
  localparam int LEN_W  = WA + 2,
  localparam int ADDR_W = WA + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  output logic              irq,
  output logic [47:0]       station_addr
);
  localparam logic [WA-1:0] W_LEN = WA'(WORDS - 3);
  localparam logic [WA-1:0] W_GEN = WA'(WORDS - 2);
  localparam logic [WA-1:0] W_CMD = WA'(WORDS - 1);

  logic          w_buf, r_buf;
  logic [WA-1:0] w_word, r_word;
  logic          unused_addr;
  assign w_buf  = wr_addr[ADDR_W-1];
  assign w_word = wr_addr[ADDR_W-2:2];
  assign r_buf  = rd_addr[ADDR_W-1];
  assign r_word = rd_addr[ADDR_W-2:2];
  assign unused_addr = ^{wr_addr[1:0], rd_addr[1:0]};

  logic [1:0] cmd_we, len_we;
  logic       gen_we, mem_we;
  always_comb begin
    cmd_we = '0;
    len_we = '0;
    gen_we = wr_en && !w_buf && (w_word == W_GEN);
    cmd_we[w_buf] = wr_en && (w_word == W_CMD);
    len_we[w_buf] = wr_en && (w_word == W_LEN);
    mem_we = wr_en && !cmd_we[w_buf] && !len_we[w_buf] && !gen_we;
  end

  cmd_t [1:0]            cmd;
  logic [1:0][LEN_W-1:0] len;
  logic                  gen, done, sel;
  logic [WA-1:0]         e_word;
  logic [31:0]           h_q, e_q, head0, head1;
  logic [1:0]            pend, prog;

  assign pend = {cmd[1].start, cmd[0].start};
  assign prog = {cmd[1].prog,  cmd[0].prog};

  ethtx_bufmem #(.WORDS(WORDS)) u_mem (
    .clk(clk), .we(mem_we), .we_buf(w_buf), .we_word(w_word), .we_data(wr_data),
    .h_buf(r_buf), .h_word(r_word), .h_q(h_q),
    .e_buf(sel), .e_word(e_word), .e_q(e_q),
    .head0(head0), .head1(head1)
  );

  ethtx_engine #(.LEN_W(LEN_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .pend(pend), .prog(prog), .len(len),
    .word_q(e_q), .sel(sel), .rd_word(e_word),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_last(tx_last), .done(done)
  );

  ethtx_regs #(.LEN_W(LEN_W), .STATION_RST(STATION_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .len_we(len_we), .gen_we(gen_we),
    .wdata(wr_data), .done(done), .done_sel(sel), .head0(head0), .head1(head1),
    .cmd(cmd), .len(len), .gen(gen), .irq(irq), .station(station_addr)
  );

  always_comb begin
    rd_data = h_q;
    if (r_word == W_CMD) begin
      rd_data = '0;
      rd_data[CMD_S] = cmd[r_buf].start;
      rd_data[CMD_P] = cmd[r_buf].prog;
      rd_data[CMD_I] = cmd[r_buf].irq_en;
    end else if (r_word == W_LEN) begin
      rd_data = {{(32-LEN_W){1'b0}}, len[r_buf]};
    end else if (r_word == W_GEN && !r_buf) begin
      rd_data = '0;
      rd_data[GEN_BIT] = gen;
    end
  end

  AST_STREAM_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> pend[sel] && !prog[sel]); // R3
endmodule

// File: tb/ethtx_ctrl_tb.sv
`timescale 1ns/1ps
module ethtx_ctrl_tb;
  localparam logic [47:0] ST_RST = 48'h0200_0000_0001;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, tx_ready = 1'b1;
  logic [11:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic tx_valid, tx_last, irq;
  logic [7:0] tx_data;
  logic [47:0] station_addr;

  always #4 clk = ~clk;

  ethtx_ctrl #(.STATION_RST(ST_RST)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_last(tx_last), .irq(irq), .station_addr(station_addr)
  );

  int total = 0, bad = 0;
  int ncap = 0, nirq = 0;
  logic [7:0] cap_d [4096];
  logic       cap_l [4096];
  int   rmode = 0;
  logic [7:0] lfsr = 8'h5B;

  always @(posedge clk) begin
    #2;
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    tx_ready <= (rmode == 0) ? 1'b1 : (rmode == 1) ? lfsr[0] : 1'b0;
  end

  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      cap_d[ncap % 4096] = tx_data;
      cap_l[ncap % 4096] = tx_last;
      ncap++;
    end
    if (rst_n && irq) nirq++;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    finish_up();
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  function automatic logic [7:0] bexp(input int seed, input int k);
    return 8'(seed + k * 7);
  endfunction

  function automatic logic [11:0] adr(input int b, input int off);
    return 12'(b * 2048 + off);
  endfunction

  task automatic fill(input int b, input int n, input int seed);
    for (int i = 0; i < (n + 3) / 4; i++)
      wr(adr(b, 4 * i), {bexp(seed, 4*i), bexp(seed, 4*i+1), bexp(seed, 4*i+2), bexp(seed, 4*i+3)});
  endtask

  task automatic wait_idle();
    logic [31:0] c0, c1;
    for (int i = 0; i < 20000; i++) begin
      rd(adr(0, 12'h7FC), c0);
      rd(adr(1, 12'h7FC), c1);
      if (!c0[0] && !c1[0]) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic chk_frame(input int base, input int n, input int seed, input string tag);
    bit ok = 1'b1;
    int first = -1;
    for (int k = 0; k < n; k++) begin
      if (cap_d[(base + k) % 4096] !== bexp(seed, k) || cap_l[(base + k) % 4096] !== (k == n - 1)) begin
        ok = 1'b0;
        if (first < 0) first = k;
      end
    end
    chk(ok, tag, (first < 0) ? 0 : cap_d[(base + first) % 4096], (first < 0) ? 0 : bexp(seed, first));
  endtask

  // fields: [63:56] buffer, [55:48] ready mode, [47:40] irq enable, [39:32] global enable,
  // [31:16] seed, [15:0] length
  localparam int NV = 6;
  localparam logic [63:0] VEC [NV] = '{
    64'h00_00_01_01_0010_0004,
    64'h01_00_01_01_0033_0007,
    64'h00_01_01_00_005A_000D,
    64'h01_01_00_01_0001_0040,
    64'h00_01_01_01_0077_0001,
    64'h01_00_01_01_00C0_07F4
  };

  initial begin
    logic [31:0] v;
    int b0, i0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(adr(0, 12'h7FC), v); chk(v == 0, "R1 cmd0", v, 0);
    rd(adr(1, 12'h7FC), v); chk(v == 0, "R1 cmd1", v, 0);
    chk(station_addr == ST_RST, "R1 station", station_addr, ST_RST);
    chk(irq == 0 && tx_valid == 0, "R1 irq/valid", {irq, tx_valid}, 0);

    // R2 register read-back masks
    wr(adr(0, 12'h7FC), 32'hFFFF_FFFA);
    rd(adr(0, 12'h7FC), v); chk(v == 32'h8, "R2 cmd mask", v, 32'h8);
    wr(adr(0, 12'h7F4), 32'hFFFF_F0A5);
    rd(adr(0, 12'h7F4), v); chk(v == 32'h0A5, "R2 len mask", v, 32'h0A5);
    wr(adr(0, 12'h7F8), 32'h7FFF_FFFF);
    rd(adr(0, 12'h7F8), v); chk(v == 0, "R2 gen mask lo", v, 0);
    wr(adr(0, 12'h7F8), 32'hFFFF_FFFF);
    rd(adr(0, 12'h7F8), v); chk(v == 32'h8000_0000, "R2 gen mask hi", v, 32'h8000_0000);
    chk(ncap == 0, "R2 no stream", ncap, 0);

    // table walk: R3 transmit, R8 irq gating
    for (int n = 0; n < NV; n++) begin
      int vb, vm, vi, vg, vs, vl;
      vb = int'(VEC[n][63:56]); vm = int'(VEC[n][55:48]);
      vi = int'(VEC[n][47:40]); vg = int'(VEC[n][39:32]);
      vs = int'(VEC[n][31:16]); vl = int'(VEC[n][15:0]);
      wr(adr(0, 12'h7F8), vg ? 32'h8000_0000 : 32'h0);
      fill(vb, vl, vs);
      wr(adr(vb, 12'h7F4), 32'(vl));
      rmode = vm;
      b0 = ncap; i0 = nirq;
      wr(adr(vb, 12'h7FC), vi ? 32'h9 : 32'h1);
      wait_idle();
      rmode = 0;
      chk(ncap - b0 == vl, $sformatf("R3 count vec%0d", n), ncap - b0, vl);
      chk_frame(b0, vl, vs, $sformatf("R3 bytes vec%0d", n));
      chk(nirq - i0 == (vi & vg), $sformatf("R8 irq vec%0d", n), nirq - i0, vi & vg);
    end

    // R5 zero length
    wr(adr(0, 12'h7F8), 32'h8000_0000);
    wr(adr(0, 12'h7F4), 32'h0);
    b0 = ncap; i0 = nirq;
    wr(adr(0, 12'h7FC), 32'h9);
    wait_idle();
    chk(ncap == b0, "R5 no bytes", ncap - b0, 0);
    chk(nirq - i0 == 1, "R5 irq", nirq - i0, 1);

    // R6 station address load from buffer 1
    wr(adr(1, 0), 32'hA1B2_C3D4);
    wr(adr(1, 4), 32'hE5F6_1234);
    b0 = ncap; i0 = nirq;
    wr(adr(1, 12'h7FC), 32'hB);
    rd(adr(1, 12'h7FC), v); chk(v == 32'hB, "R7 busy readback", v, 32'hB);
    wait_idle();
    chk(station_addr == 48'hA1B2_C3D4_E5F6, "R6 station", station_addr, 48'hA1B2_C3D4_E5F6);
    chk(ncap == b0, "R6 no bytes", ncap - b0, 0);
    chk(nirq - i0 == 1, "R6 irq", nirq - i0, 1);
    rd(adr(1, 12'h7FC), v); chk(v == 32'h8, "R7 cleared", v, 32'h8);

    // R7 write while busy ignored; R4 stall hold; R9 queued second buffer
    fill(0, 20, 8'h21);
    wr(adr(0, 12'h7F4), 32'd20);
    fill(1, 5, 8'h90);
    wr(adr(1, 12'h7F4), 32'd5);
    rmode = 2;
    b0 = ncap; i0 = nirq;
    wr(adr(0, 12'h7FC), 32'h9);
    wr(adr(0, 12'h7FC), 32'h0);
    rd(adr(0, 12'h7FC), v); chk(v == 32'h9, "R7 write ignored", v, 32'h9);
    wr(adr(1, 12'h7FC), 32'h9);
    begin
      logic [7:0] d1; logic l1;
      @(negedge clk); d1 = tx_data; l1 = tx_last;
      repeat (5) @(negedge clk);
      chk(tx_valid && tx_data == d1 && tx_last == l1, "R4 stall hold",
          {tx_valid, tx_data, tx_last}, {1'b1, d1, l1});
    end
    rd(adr(1, 12'h7FC), v); chk(v == 32'h9, "R9 pending", v, 32'h9);
    rmode = 1;
    wait_idle();
    rmode = 0;
    chk(ncap - b0 == 25, "R9 both frames", ncap - b0, 25);
    chk_frame(b0, 20, 8'h21, "R9 first frame");
    chk_frame(b0 + 20, 5, 8'h90, "R9 second frame");
    chk(nirq - i0 == 2, "R9 two irqs", nirq - i0, 2);

    // R7 write landing in completion cycle is dropped
    fill(0, 4, 8'h44);
    wr(adr(0, 12'h7F4), 32'd4);
    b0 = ncap;
    wr(adr(0, 12'h7FC), 32'h9);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (tx_valid && tx_ready && tx_last) break;
    end
    wr(adr(0, 12'h7FC), 32'h1);
    rd(adr(0, 12'h7FC), v); chk(v == 32'h8, "R7 same-cycle write dropped", v, 32'h8);
    repeat (20) @(negedge clk);
    chk(ncap - b0 == 4, "R7 no second frame", ncap - b0, 4);

    finish_up();
  end
endmodule